// File: doc/BRIEF.md
# Edge-Triggered Counter Snapshot Unit

This block records the value of a free-running counter at the moment an external pin changes level. The raw pin is first brought into the clock domain through a chain of flip-flops. The block then compares the newest synchronised sample with the one taken a cycle earlier to find an edge. A run-time select bit picks the active polarity. When it is 0, which is the default, the block reacts to high-to-low transitions. When it is 1, it reacts to low-to-high transitions.

On an active edge, the whole counter word is stored in a snapshot register and a pending flag is raised. Software sees the snapshot as two separate bytes and acknowledges the event by writing a 1 to the flag bit. Some waveform modes reuse the snapshot register as the counter's period limit. While such a mode is active, the unit ignores pin edges, so the register is never disturbed. The counter itself and any noise filtering are outside this block.

Top module: `edge_snapshot_unit`

## Requirements
- R1: With `rise_sel_i` = 1, a low-to-high transition of the synchronised pin loads `count_i` into the snapshot register, and a high-to-low transition loads nothing.
- R2: With `rise_sel_i` = 0, a high-to-low transition of the synchronised pin loads `count_i`, and a low-to-high transition loads nothing.
- R3: While `top_from_snap_i` = 1, pin edges neither change the snapshot register nor set the flag.
- R4: The snapshot is the full 16-bit counter word. Bits 7:0 appear on `snap_lo_o` and bits 15:8 appear on `snap_hi_o`.
- R5: Every accepted edge sets `snap_flag_o` to 1 on the same clock edge that loads the snapshot.
- R6: A cycle with `flag_wr_i` = 1 and `flag_wr_bit_i` = 1 clears the flag at the next clock edge. Writing 0 leaves the flag as it was.
- R7: When an accepted edge and a clear write fall in the same cycle, the flag ends up set.
- R8: An accepted edge that arrives while the flag is still set overwrites the snapshot with the new counter value, and the flag stays set.
- R9: After reset the snapshot register reads 0, the flag is 0, and all synchroniser and previous-sample stages hold 0.
- R10: A pin level first sampled at clock edge k loads the snapshot at edge k+2, using the `count_i` value present at that edge. The snapshot is unchanged after edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw, unsynchronised capture pin |
| count_i | input | 16 | Current counter value |
| rise_sel_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| top_from_snap_i | input | 1 | Snapshot register serves as TOP; blocks capture |
| flag_wr_i | input | 1 | Write strobe to the flag bit |
| flag_wr_bit_i | input | 1 | Data written to the flag bit (1 clears) |
| snap_lo_o | output | 8 | Snapshot bits 7:0 |
| snap_hi_o | output | 8 | Snapshot bits 15:8 |
| snap_flag_o | output | 1 | Capture pending flag |

## Verification
The bench toggles the pin in both directions under each polarity setting. A design with the polarity inverted, or one that triggers on both edges, would load on the wrong transition and show a stale or premature byte pair. The bench also places a clear write in exactly the cycle of an accepted edge. It sends edges every second cycle while the flag is still pending. A wrong priority would drop the flag, and a design that holds the first snapshot would keep an old counter value. Finally, it toggles the pin while capture is blocked and then lifts the block, and it times the three-edge latency. A design that loses the block, or that lets an edge seen during the block fire late, would change the snapshot at the wrong time.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    function automatic logic edge_hit(input logic cur, input logic old, input edge_pol_e pol);
        return (pol == POL_RISE) ? (cur & ~old) : (~cur & old);
    endfunction

endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = raw_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[LAST];

endmodule

// File: rtl/snap_edge_detect.sv
module snap_edge_detect
    import snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    edge_pol_e   pol;

    always_comb begin
        pol       = edge_pol_e'(rise_sel_i);
        st_d      = st_q;
        st_d.prev = sample_i;
        edge_o    = edge_hit(sample_i, st_q.prev, pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/snap_store.sv
module snap_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             block_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_wr_i,
    input  logic             clr_bit_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic             flag;
    } store_state_t;

    store_state_t st_d, st_q;
    logic         take;
    logic         clr_req;

    always_comb begin
        take    = edge_i & ~block_i;
        clr_req = clr_wr_i & clr_bit_i;
        st_d    = st_q;
        if (take) begin
            st_d.snap = count_i;
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_o = st_q.snap;
    assign flag_o = st_q.flag;

    assert_block_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> $stable(snap_o))
        else $error("R3 snapshot changed while blocked");

    assert_block_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (block_i && !flag_o && !clr_wr_i) |=> !flag_o)
        else $error("R3 flag set while blocked");

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !block_i) |=> flag_o)
        else $error("R5 flag not set by capture");

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_bit_i && !(edge_i && !block_i)) |=> !flag_o)
        else $error("R6 flag not cleared");

    assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !edge_i && clr_wr_i && !clr_bit_i) |=> flag_o)
        else $error("R6 zero write cleared flag");

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !block_i && clr_wr_i && clr_bit_i) |=> flag_o)
        else $error("R7 clear beat capture");

    assert_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !block_i && flag_o) |=> (flag_o && snap_o == $past(count_i)))
        else $error("R8 overwrite failed");

endmodule

// File: rtl/edge_snapshot_unit.sv
module edge_snapshot_unit #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_i,
    input  logic [2*BYTE_W-1:0] count_i,
    input  logic                rise_sel_i,
    input  logic                top_from_snap_i,
    input  logic                flag_wr_i,
    input  logic                flag_wr_bit_i,
    output logic [BYTE_W-1:0]   snap_lo_o,
    output logic [BYTE_W-1:0]   snap_hi_o,
    output logic                snap_flag_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             pin_sync;
    logic             edge_seen;
    logic [CNT_W-1:0] snap_word;

    snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (pin_sync)
    );

    snap_edge_detect u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (pin_sync),
        .rise_sel_i (rise_sel_i),
        .edge_o     (edge_seen)
    );

    snap_store #(.CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_seen),
        .block_i   (top_from_snap_i),
        .count_i   (count_i),
        .clr_wr_i  (flag_wr_i),
        .clr_bit_i (flag_wr_bit_i),
        .snap_o    (snap_word),
        .flag_o    (snap_flag_o)
    );

    assign snap_lo_o = snap_word[BYTE_W-1:0];
    assign snap_hi_o = snap_word[CNT_W-1:BYTE_W];

    assert_rise_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_sel_i && !top_from_snap_i && $rose(pin_sync)) |=>
            ({snap_hi_o, snap_lo_o} == $past(count_i)))
        else $error("R1 rising edge not captured");

    assert_fall_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_sel_i && !top_from_snap_i && $fell(pin_sync)) |=>
            ({snap_hi_o, snap_lo_o} == $past(count_i)))
        else $error("R2 falling edge not captured");

    assert_reset_zero_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (snap_lo_o == '0 && snap_hi_o == '0 && !snap_flag_o))
        else $error("R9 reset state wrong");

endmodule

// File: tb/edge_snapshot_unit_bench.sv
module edge_snapshot_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] cnt = 16'h0000;
    logic        rise_sel = 1'b0;
    logic        top_blk = 1'b0;
    logic        clr_wr = 1'b0;
    logic        clr_bit = 1'b0;
    logic [7:0]  lo, hi;
    logic        flag;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string phase  = "R9";
    bit    cmp_en = 1'b0;

    // reference model state
    bit          hist[$];
    logic [15:0] m_snap;
    logic        m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_snapshot_unit u_edge_snapshot_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .pin_i           (pin),
        .count_i         (cnt),
        .rise_sel_i      (rise_sel),
        .top_from_snap_i (top_blk),
        .flag_wr_i       (clr_wr),
        .flag_wr_bit_i   (clr_bit),
        .snap_lo_o       (lo),
        .snap_hi_o       (hi),
        .snap_flag_o     (flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // counter stimulus, changes away from the active edge
    always @(negedge clk) if (rst_n) cnt <= cnt + 16'h0137;

    // behavioural model: pin level sampled at edge k acts at edge k+2 (R10)
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            hist   = {1'b0, 1'b0, 1'b0};
            m_snap = 16'h0;
            m_flag = 1'b0;
        end else begin
            int  n;
            bit  cur, old, hit;
            n   = hist.size();
            cur = hist[n-2];
            old = hist[n-3];
            hit = rise_sel ? (cur && !old) : (!cur && old);
            if (hit && !top_blk) begin
                m_snap = cnt;
                m_flag = 1'b1;
            end else if (clr_wr && clr_bit) begin
                m_flag = 1'b0;
            end
            hist.push_back(pin);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    // every-cycle comparison; R4 byte split checked each cycle
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R4 low byte", lo, m_snap[7:0]);
            check("R4 high byte", hi, m_snap[15:8]);
            check({phase, " flag"}, flag, m_flag);
        end
    end

    always @(posedge clk) begin
        if (cycles >= WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flag(input bit b);
        @(negedge clk);
        clr_wr  = 1'b1;
        clr_bit = b;
        @(negedge clk);
        clr_wr  = 1'b0;
        clr_bit = 1'b0;
    endtask

    initial begin
        logic [15:0] old_snap;

        // R9 reset state
        tick(3);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tick(1);
        check("R9 snapshot after reset", {hi, lo}, 16'h0000);
        check("R9 flag after reset", flag, 0);
        tick(3);

        // R1 rising edges, falling edges ignored
        phase = "R1";
        rise_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pin = 1'b1; tick(5);
            check("R1 rise sets flag", flag, 1);
            old_snap = {hi, lo};
            pin = 1'b0; tick(5);
            check("R1 fall ignored", {hi, lo}, old_snap);
            clear_flag(1'b1); tick(1);
        end

        // R2 falling edges, rising edges ignored
        phase = "R2";
        rise_sel = 1'b0;
        for (int i = 0; i < 3; i++) begin
            old_snap = {hi, lo};
            pin = 1'b1; tick(5);
            check("R2 rise ignored", {hi, lo}, old_snap);
            pin = 1'b0; tick(5);
            check("R2 fall sets flag", flag, 1);
            clear_flag(1'b1); tick(1);
        end

        // R6 zero write keeps, one write clears
        phase = "R6";
        pin = 1'b1; tick(3); pin = 1'b0; tick(5);
        clear_flag(1'b0); tick(1);
        check("R6 zero write keeps flag", flag, 1);
        clear_flag(1'b1); tick(1);
        check("R6 one write clears flag", flag, 0);

        // R3 blocked while snapshot is TOP
        phase = "R3";
        top_blk = 1'b1;
        old_snap = {hi, lo};
        for (int i = 0; i < 4; i++) begin
            pin = ~pin; tick(3);
        end
        check("R3 snapshot held", {hi, lo}, old_snap);
        check("R3 flag held", flag, 0);
        top_blk = 1'b0;
        tick(6);
        check("R3 no late capture", {hi, lo}, old_snap);

        // R10 latency, falling polarity, pin currently low
        phase = "R10";
        pin = 1'b1; tick(4);
        old_snap = {hi, lo};
        pin = 1'b0;
        tick(1);
        check("R10 unchanged after edge k", {hi, lo}, old_snap);
        tick(1);
        check("R10 unchanged after edge k+1", {hi, lo}, old_snap);
        tick(1);
        check("R10 loaded after edge k+2", {hi, lo}, m_snap);
        check("R10 flag after edge k+2", flag, 1);
        clear_flag(1'b1); tick(2);

        // R7 capture and clear in the same cycle
        phase = "R7";
        pin = 1'b1; tick(4);
        clear_flag(1'b1);
        pin = 1'b0;
        tick(2);
        clr_wr = 1'b1; clr_bit = 1'b1;
        tick(1);
        clr_wr = 1'b0; clr_bit = 1'b0;
        check("R7 set beats clear", flag, 1);
        tick(2);

        // R8 back-to-back captures with flag pending
        phase = "R8";
        rise_sel = 1'b1;
        for (int i = 0; i < 12; i++) begin
            pin = ~pin; tick(1);
        end
        tick(3);
        check("R8 flag still set", flag, 1);
        check("R8 latest value kept", {hi, lo}, m_snap);

        tick(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule